// File: doc/BRIEF.md
# Posted-Write Clock-Crossing Register Bridge

This block carries register writes from a fast bus clock into a slower, unrelated timer clock. A timer keeps several registers there, such as the reload value, the running count and the control word. Each of these registers has its own lane. A lane holds the written value on the bus side and passes it over with a toggle request. It gets a toggle acknowledge back. Each direction goes through a chain of synchronizer flops. While a lane is busy, its bit in the in-flight status word reads 1. The timer datapath is not part of the block. Its destination registers are brought out flat on `fn_regs`.

There are two write modes. In posted mode the bus never waits. Software polls the in-flight word, which is read directly and needs no wait, before it touches a busy register again. A write to a register that is still busy is discarded and raises a sticky error flag. In direct mode the in-flight word reads zero. Instead, `bus_wait` holds the bus off while any transfer is in flight, and a register write issued during that time is discarded with the same error. A parameter sets the reset value of the mode bit. A read of a bridged register returns the value of the last write that completed its transfer.

Top module: `pws_bridge`

## Requirements
- R1: After reset, the control word reads the posted-mode reset parameter in bit 0 and 0 in bit 1. The in-flight word, every register readback, every destination register and `bus_wait` are all 0.
- R2: In posted mode, an accepted write to register i sets bit i of the in-flight word (address NREG) by the next bus cycle, and `bus_wait` stays 0.
- R3: Once bit i of the in-flight word is clear again, destination register i holds the written value.
- R4: A register read (addresses 0 to NREG-1) returns the last value whose transfer completed. While a new write is still in flight, it returns the previous value.
- R5: In posted mode, a write to a register whose bit is set is discarded: the destination keeps the earlier value. The write sets the error flag, which is bit 1 of the control word (address NREG+1).
- R6: In direct mode (control bit 0 = 0), `bus_wait` is 1 while any transfer is in flight, and the in-flight word reads 0.
- R7: In direct mode, a register write issued while `bus_wait` is 1 is discarded, and it sets the error flag.
- R8: A write to the control word sets the mode from data bit 0. It clears the error flag when data bit 1 is 0 and leaves the flag as it is when data bit 1 is 1. Writes to the in-flight word's address or to unused addresses change nothing.
- R9: Writes to different registers in consecutive cycles are all accepted, and their transfers run side by side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Bus-domain reset, active low |
| fn_clk | input | 1 | Timer functional clock |
| fn_rst_n | input | 1 | Functional-domain reset, active low |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address (combinational read) |
| rd_data | output | DW | Read data |
| bus_wait | output | 1 | Direct mode: transfer in flight, hold the bus |
| fn_regs | output | NREG*DW | Destination registers in the functional domain, register i at bits i*DW |

## Verification
The bench uses the defaults: three 32-bit registers, two synchronizer stages and posted mode at reset, with the functional clock at 10 ns against a 4 ns bus clock. Because the synchronizers make a round trip last many bus cycles, the cycle right after a write is always still inside its transfer. This makes back-to-back writes to the same register, the direct-mode stall and the value read back during a transfer all reliable, repeatable cases. Random mode switches and data exercise every lane in both modes.

// File: rtl/pws_pkg.sv
package pws_pkg;
   typedef enum logic [1:0] {
      SEL_LANE = 2'd0,
      SEL_STAT = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } sel_e;

   localparam int unsigned CTRL_MODE_BIT = 0;
   localparam int unsigned CTRL_ERR_BIT  = 1;
endpackage

// File: rtl/pws_sync.sv
module pws_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= d;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pws_lane.sv
module pws_lane #(
   parameter int DW          = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic          bus_clk,
   input  logic          bus_rst_n,
   input  logic          fn_clk,
   input  logic          fn_rst_n,
   input  logic          start,
   input  logic [DW-1:0] start_data,
   output logic          pending,
   output logic [DW-1:0] shadow,
   output logic [DW-1:0] fn_value
);
   logic [DW-1:0] hold;
   logic          req_t, ack_s, ack_prev;
   logic          req_s, ack_t;

   // bus side: capture and request toggle
   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) begin
         hold     <= '0;
         req_t    <= 1'b0;
         ack_prev <= 1'b0;
         shadow   <= '0;
      end else begin
         if (start) begin
            hold  <= start_data;
            req_t <= ~req_t;
         end
         ack_prev <= ack_s;
         if (ack_s != ack_prev) shadow <= hold;
      end
   end

   assign pending = req_t ^ ack_s;

   pws_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(fn_clk), .rst_n(fn_rst_n), .d(req_t), .q(req_s)
   );

   // functional side: load held value, answer with acknowledge toggle
   always_ff @(posedge fn_clk or negedge fn_rst_n) begin
      if (!fn_rst_n) begin
         fn_value <= '0;
         ack_t    <= 1'b0;
      end else if (req_s != ack_t) begin
         fn_value <= hold;
         ack_t    <= req_s;
      end
   end

   pws_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_t), .q(ack_s)
   );

   // R5: a lane only starts a transfer when idle
   a_r5_start_when_idle: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      start |-> !pending);

   // R3: destination changes only on a delivered request
   a_r3_fn_changes_on_request: assert property (@(posedge fn_clk) disable iff (!fn_rst_n)
      !$stable(fn_value) |-> $past(req_s != ack_t));

   // R4: readback follows the completed transfer
   a_r4_shadow_after_done: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      $fell(pending) |=> shadow == $past(hold));
endmodule

// File: rtl/pws_ctrl.sv
module pws_ctrl
   import pws_pkg::*;
#(
   parameter int NREG         = 3,
   parameter int AW           = 3,
   parameter bit POSTED_RESET = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [1:0]      wr_bits,
   input  logic [NREG-1:0] pend,
   output logic [NREG-1:0] start,
   output logic            posted,
   output logic            err,
   output logic            bus_wait
);
   localparam logic [AW-1:0] CTRL_ADDR = AW'(NREG + 1);

   logic [NREG-1:0] hit;
   logic            blocked_any;
   logic            ctrl_wr;

   always_comb begin
      for (int i = 0; i < NREG; i++) begin
         hit[i] = wr_en && (wr_addr == AW'(i));
      end
   end

   assign bus_wait    = !posted && (|pend);
   assign blocked_any = |(hit & (pend | {NREG{bus_wait}}));
   assign start       = hit & ~pend & {NREG{!bus_wait}};
   assign ctrl_wr     = wr_en && (wr_addr == CTRL_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         posted <= POSTED_RESET;
         err    <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            posted <= wr_bits[CTRL_MODE_BIT];
            err    <= err & wr_bits[CTRL_ERR_BIT];
         end else if (blocked_any) begin
            err <= 1'b1;
         end
      end
   end

   // R5 / R7: the error flag only rises on a bus write
   a_r5_err_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> $past(wr_en));

   // R7: nothing starts while the bus is held off
   a_r7_no_start_while_wait: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wait |-> start == '0);
endmodule

// File: rtl/pws_bridge.sv
module pws_bridge
   import pws_pkg::*;
#(
   parameter int NREG         = 3,
   parameter int DW           = 32,
   parameter int SYNC_STAGES  = 2,
   parameter bit POSTED_RESET = 1'b1,
   parameter int AW           = $clog2(NREG + 2)
) (
   input  logic               bus_clk,
   input  logic               bus_rst_n,
   input  logic               fn_clk,
   input  logic               fn_rst_n,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   input  logic [DW-1:0]      wr_data,
   input  logic [AW-1:0]      rd_addr,
   output logic [DW-1:0]      rd_data,
   output logic               bus_wait,
   output logic [NREG*DW-1:0] fn_regs
);
   localparam logic [AW-1:0] STAT_ADDR = AW'(NREG);
   localparam logic [AW-1:0] CTRL_ADDR = AW'(NREG + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (NREG < 1 || NREG > DW) begin : g_bad_nreg
      $error("NREG must be between 1 and DW");
   end
   if (DW < 2) begin : g_bad_dw
      $error("DW must be at least 2");
   end
   if ((1 << AW) < NREG + 2) begin : g_bad_aw
      $error("AW too narrow for the address map");
   end

   logic [NREG-1:0]         pend, start;
   logic [NREG-1:0][DW-1:0] shadow;
   logic                    posted, err;

   pws_ctrl #(
      .NREG(NREG), .AW(AW), .POSTED_RESET(POSTED_RESET)
   ) u_ctrl (
      .clk(bus_clk), .rst_n(bus_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_bits(wr_data[1:0]), .pend(pend), .start(start), .posted(posted),
      .err(err), .bus_wait(bus_wait)
   );

   for (genvar g = 0; g < NREG; g++) begin : g_lane
      pws_lane #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_lane (
         .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
         .fn_clk(fn_clk), .fn_rst_n(fn_rst_n),
         .start(start[g]), .start_data(wr_data),
         .pending(pend[g]), .shadow(shadow[g]),
         .fn_value(fn_regs[g*DW +: DW])
      );
   end

   sel_e sel;
   always_comb begin
      if (rd_addr < STAT_ADDR)       sel = SEL_LANE;
      else if (rd_addr == STAT_ADDR) sel = SEL_STAT;
      else if (rd_addr == CTRL_ADDR) sel = SEL_CTRL;
      else                           sel = SEL_NONE;
   end

   always_comb begin
      rd_data = '0;
      case (sel)
         SEL_LANE: begin
            for (int i = 0; i < NREG; i++) begin
               if (rd_addr == AW'(i)) rd_data = shadow[i];
            end
         end
         SEL_STAT: if (posted) rd_data[NREG-1:0] = pend;
         SEL_CTRL: begin
            rd_data[CTRL_MODE_BIT] = posted;
            rd_data[CTRL_ERR_BIT]  = err;
         end
         default: rd_data = '0;
      endcase
   end

   // R6: in direct mode software sees an empty in-flight word
   a_r6_stat_hidden_direct: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (!posted && rd_addr == STAT_ADDR) |-> rd_data == '0);
endmodule

// File: tb/sim_pws_bridge.sv
module sim_pws_bridge;
   localparam int NREG = 3;
   localparam int DW   = 32;
   localparam int AW   = 3;
   localparam logic [AW-1:0] STAT = 3'd3;
   localparam logic [AW-1:0] CTRL = 3'd4;

   logic bclk = 1'b0, fclk = 1'b0;
   logic brst_n = 1'b0, frst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic bus_wait;
   logic [NREG*DW-1:0] fn_regs;

   int total = 0, bad = 0, cyc = 0;
   logic [DW-1:0] exp_val [NREG];

   always #2 bclk = ~bclk;
   initial begin #1; forever #5 fclk = ~fclk; end

   pws_bridge #(.NREG(NREG), .DW(DW), .SYNC_STAGES(2), .POSTED_RESET(1'b1)) u0 (
      .bus_clk(bclk), .bus_rst_n(brst_n), .fn_clk(fclk), .fn_rst_n(frst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .bus_wait(bus_wait), .fn_regs(fn_regs)
   );

   function automatic logic [DW-1:0] ctrl_word(bit posted, bit err);
      return {{(DW-2){1'b0}}, err, posted};
   endfunction

   function automatic logic [DW-1:0] stat_word(int idx);
      return DW'(1) << idx;
   endfunction

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge bclk) begin
      cyc++;
      if (cyc > 150000) begin
         total++; bad++;
         $display("FAIL watchdog: act=%0d expected<=150000 cycles", cyc);
         summary();
      end
   end

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: act=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bwrite(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge bclk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge bclk);
      wr_en = 1'b0;
   endtask

   task automatic bread(logic [AW-1:0] a, output logic [DW-1:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic drain();
      logic [DW-1:0] s;
      for (int k = 0; k < 500; k++) begin
         @(negedge bclk);
         bread(STAT, s);
         if (s == '0 && !bus_wait) break;
      end
      repeat (2) @(negedge bclk);
   endtask

   task automatic check_all(string tag);
      logic [DW-1:0] v;
      for (int i = 0; i < NREG; i++) begin
         check(tag, fn_regs[i*DW +: DW], exp_val[i]);
         bread(AW'(i), v);
         check(tag, v, exp_val[i]);
      end
   endtask

   initial begin
      logic [DW-1:0] v, d1, d2;
      int unsigned seed;
      seed = $urandom(32'd4242);
      for (int i = 0; i < NREG; i++) exp_val[i] = '0;
      repeat (4) @(negedge bclk);
      brst_n = 1'b1; frst_n = 1'b1;
      repeat (3) @(negedge bclk);

      // R1 reset state
      bread(CTRL, v); check("R1 ctrl", v, ctrl_word(1, 0));
      bread(STAT, v); check("R1 stat", v, '0);
      check("R1 bus_wait", DW'(bus_wait), '0);
      check_all("R1 regs");

      // R2 R3 R4 posted write
      bwrite(3'd1, 32'hA5A5_0001);
      bread(STAT, v); check("R2 stat bit", v, stat_word(1));
      check("R2 no wait", DW'(bus_wait), '0);
      bread(3'd1, v); check("R4 old value while pending", v, '0);
      drain();
      exp_val[1] = 32'hA5A5_0001;
      bread(STAT, v); check("R3 stat clear", v, '0);
      check_all("R3 R4 delivered");

      // R5 write to busy register dropped
      bwrite(3'd0, 32'h1111_2222);
      bwrite(3'd0, 32'h3333_4444);
      bread(CTRL, v); check("R5 err set", v, ctrl_word(1, 1));
      drain();
      exp_val[0] = 32'h1111_2222;
      check_all("R5 first kept");
      bwrite(CTRL, 32'h3);
      bread(CTRL, v); check("R8 err kept with bit1=1", v, ctrl_word(1, 1));
      bwrite(CTRL, 32'h1);
      bread(CTRL, v); check("R8 err cleared", v, ctrl_word(1, 0));

      // R9 parallel lanes
      bwrite(3'd0, 32'h0000_00A0);
      bwrite(3'd1, 32'h0000_00B1);
      bwrite(3'd2, 32'h0000_00C2);
      bread(STAT, v); check("R9 all pending", v, 32'h7);
      bread(CTRL, v); check("R9 no error", v, ctrl_word(1, 0));
      drain();
      exp_val[0] = 32'hA0; exp_val[1] = 32'hB1; exp_val[2] = 32'hC2;
      check_all("R9 delivered");

      // R8 ignored addresses
      bwrite(STAT, 32'hFFFF_FFFF);
      bwrite(3'd6, 32'hDEAD_BEEF);
      bread(STAT, v); check("R8 stat write ignored", v, '0);
      bread(CTRL, v); check("R8 ctrl untouched", v, ctrl_word(1, 0));
      check("R8 no wait", DW'(bus_wait), '0);
      repeat (20) @(negedge bclk);
      check_all("R8 regs untouched");

      // R6 R7 direct mode
      bwrite(CTRL, 32'h0);
      bread(CTRL, v); check("R8 mode off", v, ctrl_word(0, 0));
      bwrite(3'd2, 32'h5555_AAAA);
      check("R6 bus_wait high", DW'(bus_wait), 32'h1);
      bread(STAT, v); check("R6 stat reads zero", v, '0);
      bwrite(3'd1, 32'h7777_7777);
      bread(CTRL, v); check("R7 err set", v, ctrl_word(0, 1));
      drain();
      exp_val[2] = 32'h5555_AAAA;
      check("R6 wait released", DW'(bus_wait), '0);
      check_all("R7 dropped write");
      bwrite(CTRL, 32'h0);
      bread(CTRL, v); check("R8 err cleared direct", v, ctrl_word(0, 0));

      // random mix
      for (int it = 0; it < 60; it++) begin
         bit pm, dbl;
         int idx;
         pm  = $urandom_range(1, 0);
         dbl = $urandom_range(3, 0) == 0;
         idx = $urandom_range(NREG - 1, 0);
         d1  = $urandom;
         d2  = $urandom;
         bwrite(CTRL, ctrl_word(pm, 0));
         bwrite(AW'(idx), d1);
         if (pm) begin
            bread(STAT, v); check("R2 random stat", v, stat_word(idx));
         end else begin
            check("R6 random wait", DW'(bus_wait), 32'h1);
         end
         bread(AW'(idx), v); check("R4 random old", v, exp_val[idx]);
         if (dbl) begin
            bwrite(AW'(idx), d2);
            bread(CTRL, v); check("R5 R7 random err", v, ctrl_word(pm, 1));
         end
         drain();
         exp_val[idx] = d1;
         check_all("R3 random delivered");
      end

      summary();
   end
endmodule